// File: doc/BRIEF.md
# MII PHY Discovery and Setup Sequencer

This block runs once after reset and finds the Ethernet transceivers hanging off a management (MDIO) bus. It sends register read and write requests through a simple request/acknowledge master port; the serial MDIO signalling itself sits in a separate block. It checks each PHY address, in the order 1 to 31 and then 0, for a transceiver. For each one it accepts, it settles on an advertisement word and rewrites register 4 when the word must change. It then puts the control register into either autonegotiation or a forced speed and duplex.

The addresses it accepts go into a small table of `MAX_PHYS` slots, and the count is reported with a one-cycle done pulse. Four configuration inputs steer the setup: whether media is forced, whether full duplex or 100 Mb/s is forced, and an optional preset advertisement. Each table slot can also carry a stored advertisement. A separate input says a transceiver is expected. If none is found, slot 0 falls back to address 1 and a warning flag rises.

Top module: `phy_scan_seq`

## Requirements
- R1: Status (register 1) reads go to addresses 1, 2, …, 31 and then 0, one per address. The scan stops as soon as `MAX_PHYS` PHYs are recorded, so no further addresses are read.
- R2: A PHY is accepted when status AND 0x8301 equals 0x8001. It is also accepted when status bit 15 is 0 and status AND 0x7800 is nonzero. A response of 0xFFFF is rejected. A rejected address gets no further access.
- R3: If the advertisement read from register 4 has bits 5–9 all zero, the working advertisement is ((status >> 6) AND 0x3E0) OR 1. Otherwise it is the value read.
- R4: The chosen advertisement is picked in this order: the global value (loaded from `cfg_adv_preset` at start), then this slot's `cfg_slot_adv` entry, then the working advertisement. A value of zero means absent. When the working value is picked, it becomes the global value for later PHYs.
- R5: Register 4 is written with the chosen advertisement only when that value differs from the working advertisement. Register 0 and register 4 are the only registers ever written.
- R6: When `cfg_forced` is 0, control bit 12 is set, and bit 9 is also set if bit 12 was clear. When `cfg_forced` is 1, bit 12 is cleared.
- R7: The new control word has bits 7, 8, 10, 11, 13, 14 and 15 cleared. Bit 8 is then set if `cfg_full_duplex` is 1, and bit 13 if `cfg_speed100` is 1.
- R8: If bit 12 changed, the new control word is written to register 0 twice, with at least `SETTLE_CYC` cycles between the two acknowledges. Otherwise it is written once if it differs from the value read, and not written at all if it is the same.
- R9: Accepted addresses fill slots 0 upward (slot k at bits 5k+4..5k), and `phy_count` gives their number. `done` pulses for exactly one cycle after the last transaction, and no request follows.
- R10: If no PHY is found and `cfg_expect_phy` is 1, slot 0 reads 1, `no_phy_warn` is 1 and `phy_count` is 0. With `cfg_expect_phy` 0, the table stays zero and no warning is raised.
- R11: A request (`mdio_req`) and its address, register, direction and write data stay stable until `mdio_ack`.
- R12: During reset, `done`, `no_phy_warn`, `phy_count`, `mdio_req` and the table are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; the scan starts on release |
| cfg_forced | input | 1 | 1: media forced (autonegotiation off) |
| cfg_full_duplex | input | 1 | Force full duplex in the control word |
| cfg_speed100 | input | 1 | Force 100 Mb/s in the control word |
| cfg_expect_phy | input | 1 | A transceiver is expected to be present |
| cfg_adv_preset | input | 16 | Global advertisement preset, 0 = none |
| cfg_slot_adv | input | 16*MAX_PHYS | Stored advertisement per slot, 0 = none |
| mdio_req | output | 1 | Management transaction request |
| mdio_wr | output | 1 | 1 = write, 0 = read |
| mdio_phy | output | 5 | PHY address |
| mdio_reg | output | 5 | Register address |
| mdio_wdata | output | 16 | Write data |
| mdio_ack | input | 1 | One-cycle completion; `mdio_rdata` is valid with it |
| mdio_rdata | input | 16 | Read data |
| phy_addr_tbl | output | 5*MAX_PHYS | Recorded PHY addresses, slot 0 in the low bits |
| phy_count | output | $clog2(MAX_PHYS+1) | Number of PHYs found |
| no_phy_warn | output | 1 | Expected transceiver missing |
| done | output | 1 | One-cycle completion pulse |

## Verification
Each new request appears on the port one cycle after the previous acknowledge, or two cycles later when a decision state lies in between. The bench's bus model therefore logs the request fields at the acknowledge, not at request rise. The two control writes after an autonegotiation change are timestamped at their acknowledges, and their gap is compared with `SETTLE_CYC`. Table, count and warning are read on the falling edge where `done` is first seen high. The pulse width and the absence of later requests are checked over the following falling edges.

// File: rtl/phy_scan_pkg.sv
package phy_scan_pkg;

   typedef enum logic [3:0] {
      ST_BOOT, ST_RD_STAT, ST_RD_CTRL, ST_RD_ADV, ST_CHOOSE, ST_WR_ADV,
      ST_CTRL, ST_WR_CTRL1, ST_SETTLE, ST_WR_CTRL2, ST_NEXT, ST_FINISH, ST_DONE
   } scan_state_t;

   localparam logic [4:0]  REG_CTRL      = 5'd0;
   localparam logic [4:0]  REG_STAT      = 5'd1;
   localparam logic [4:0]  REG_ADV       = 5'd4;

   localparam logic [15:0] CTRL_ANE      = 16'h1000;
   localparam logic [15:0] CTRL_RESTART  = 16'h0200;
   localparam logic [15:0] CTRL_FDX      = 16'h0100;
   localparam logic [15:0] CTRL_SPD100   = 16'h2000;
   // collision test, duplex, isolate, power down, speed, loopback, reset
   localparam logic [15:0] CTRL_SCRUB    = 16'hED80;

   localparam logic [15:0] ABILITY_MASK  = 16'h03E0;
   localparam logic [5:0]  SCAN_FIRST    = 6'd1;
   localparam logic [5:0]  SCAN_LAST     = 6'd32;

endpackage

// File: rtl/phy_qualify.sv
module phy_qualify
   import phy_scan_pkg::*;
(
   input  logic [15:0] stat_word,
   input  logic [15:0] adv_word,
   output logic        accept,
   output logic [15:0] adv_eff
);

   logic pattern_a;
   logic pattern_b;

   always_comb begin
      pattern_a = ((stat_word & 16'h8301) == 16'h8001);
      pattern_b = !stat_word[15] && ((stat_word & 16'h7800) != 16'h0000);
      accept    = pattern_a || pattern_b;
      if ((adv_word & ABILITY_MASK) == 16'h0000)
         adv_eff = ((stat_word >> 6) & ABILITY_MASK) | 16'h0001;
      else
         adv_eff = adv_word;
   end

endmodule

// File: rtl/phy_ctrl_compose.sv
module phy_ctrl_compose
   import phy_scan_pkg::*;
(
   input  logic [15:0] cur_ctrl,
   input  logic        forced,
   input  logic        full_duplex,
   input  logic        speed100,
   output logic [15:0] new_ctrl,
   output logic        ane_flip,
   output logic        differs
);

   logic [15:0] work;

   always_comb begin
      work     = forced ? (cur_ctrl & ~CTRL_ANE) : (cur_ctrl | CTRL_ANE);
      ane_flip = (work != cur_ctrl);
      if (!forced && ane_flip)
         work = work | CTRL_RESTART;
      work = work & ~CTRL_SCRUB;
      if (full_duplex)
         work = work | CTRL_FDX;
      if (speed100)
         work = work | CTRL_SPD100;
      new_ctrl = work;
      differs  = (work != cur_ctrl);
   end

endmodule

// File: rtl/scan_wait_timer.sv
module scan_wait_timer #(
   parameter int unsigned CYC = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic expired
);

   localparam int unsigned CW = $clog2(CYC + 1);

   generate
      if (CYC < 1) begin : g_bad_cyc
         $error("scan_wait_timer: CYC must be at least 1");
      end
   endgenerate

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (start)
         cnt_q <= CW'(CYC);
      else if (cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign expired = (cnt_q == '0);

   // R8: the countdown never leaves its range
   p_timer_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CW'(CYC));

endmodule

// File: rtl/phy_scan_seq.sv
module phy_scan_seq
   import phy_scan_pkg::*;
#(
   parameter int unsigned MAX_PHYS   = 4,
   parameter int unsigned SETTLE_CYC = 16,
   localparam int unsigned CNT_W     = $clog2(MAX_PHYS + 1)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    cfg_forced,
   input  logic                    cfg_full_duplex,
   input  logic                    cfg_speed100,
   input  logic                    cfg_expect_phy,
   input  logic [15:0]             cfg_adv_preset,
   input  logic [16*MAX_PHYS-1:0]  cfg_slot_adv,
   output logic                    mdio_req,
   output logic                    mdio_wr,
   output logic [4:0]              mdio_phy,
   output logic [4:0]              mdio_reg,
   output logic [15:0]             mdio_wdata,
   input  logic                    mdio_ack,
   input  logic [15:0]             mdio_rdata,
   output logic [5*MAX_PHYS-1:0]   phy_addr_tbl,
   output logic [CNT_W-1:0]        phy_count,
   output logic                    no_phy_warn,
   output logic                    done
);

   generate
      if (MAX_PHYS < 2 || MAX_PHYS > 32) begin : g_bad_max
         $error("phy_scan_seq: MAX_PHYS must be within 2..32");
      end
   endgenerate

   scan_state_t st;
   logic [5:0]  idx_q;
   logic [CNT_W-1:0] cnt_q;
   logic [15:0] stat_q, ctrl_q, adv_q, chosen_q, glob_q, new_ctrl_q;
   logic        ane_sw_q, need_ctrl_q, done_q, warn_q;

   // ---------------- qualification and control composition
   logic [15:0] stat_sel, adv_eff;
   logic        accept;
   assign stat_sel = (st == ST_RD_STAT) ? mdio_rdata : stat_q;

   phy_qualify u_qual (
      .stat_word (stat_sel),
      .adv_word  (mdio_rdata),
      .accept    (accept),
      .adv_eff   (adv_eff)
   );

   logic [15:0] cmp_ctrl;
   logic        cmp_flip, cmp_diff;

   phy_ctrl_compose u_comp (
      .cur_ctrl    (ctrl_q),
      .forced      (cfg_forced),
      .full_duplex (cfg_full_duplex),
      .speed100    (cfg_speed100),
      .new_ctrl    (cmp_ctrl),
      .ane_flip    (cmp_flip),
      .differs     (cmp_diff)
   );

   logic tmr_start, tmr_zero;
   assign tmr_start = (st == ST_WR_CTRL1) && mdio_ack;

   scan_wait_timer #(.CYC(SETTLE_CYC)) u_wait (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (tmr_start),
      .expired (tmr_zero)
   );

   // ---------------- per-slot stored advertisement selection
   logic [15:0] slot_adv_arr [MAX_PHYS];
   logic [15:0] slot_sel;
   logic [15:0] pick;

   genvar g;
   generate
      for (g = 0; g < MAX_PHYS; g++) begin : g_slot_adv
         assign slot_adv_arr[g] = cfg_slot_adv[16*g +: 16];
      end
   endgenerate

   always_comb begin
      slot_sel = 16'h0000;
      for (int k = 0; k < MAX_PHYS; k++)
         if (cnt_q == CNT_W'(k))
            slot_sel = slot_adv_arr[k];
      if (glob_q != 16'h0000)
         pick = glob_q;
      else if (slot_sel != 16'h0000)
         pick = slot_sel;
      else
         pick = adv_q;
   end

   // ---------------- sequencer
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st          <= ST_BOOT;
         idx_q       <= SCAN_FIRST;
         cnt_q       <= '0;
         stat_q      <= '0;
         ctrl_q      <= '0;
         adv_q       <= '0;
         chosen_q    <= '0;
         glob_q      <= '0;
         new_ctrl_q  <= '0;
         ane_sw_q    <= 1'b0;
         need_ctrl_q <= 1'b0;
         done_q      <= 1'b0;
         warn_q      <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (st)
            ST_BOOT: begin
               glob_q <= cfg_adv_preset;
               st     <= ST_RD_STAT;
            end
            ST_RD_STAT: if (mdio_ack) begin
               stat_q <= mdio_rdata;
               st     <= accept ? ST_RD_CTRL : ST_NEXT;
            end
            ST_RD_CTRL: if (mdio_ack) begin
               ctrl_q <= mdio_rdata;
               st     <= ST_RD_ADV;
            end
            ST_RD_ADV: if (mdio_ack) begin
               adv_q <= adv_eff;
               st    <= ST_CHOOSE;
            end
            ST_CHOOSE: begin
               chosen_q    <= pick;
               if (glob_q == 16'h0000 && slot_sel == 16'h0000)
                  glob_q <= adv_q;
               cnt_q       <= cnt_q + 1'b1;
               new_ctrl_q  <= cmp_ctrl;
               ane_sw_q    <= cmp_flip;
               need_ctrl_q <= cmp_diff;
               st          <= (pick != adv_q) ? ST_WR_ADV : ST_CTRL;
            end
            ST_WR_ADV: if (mdio_ack) st <= ST_CTRL;
            ST_CTRL: begin
               if (ane_sw_q)         st <= ST_WR_CTRL1;
               else if (need_ctrl_q) st <= ST_WR_CTRL2;
               else                  st <= ST_NEXT;
            end
            ST_WR_CTRL1: if (mdio_ack) st <= ST_SETTLE;
            ST_SETTLE:   if (tmr_zero) st <= ST_WR_CTRL2;
            ST_WR_CTRL2: if (mdio_ack) st <= ST_NEXT;
            ST_NEXT: begin
               if (cnt_q == CNT_W'(MAX_PHYS) || idx_q == SCAN_LAST)
                  st <= ST_FINISH;
               else begin
                  idx_q <= idx_q + 1'b1;
                  st    <= ST_RD_STAT;
               end
            end
            ST_FINISH: begin
               if (cnt_q == '0 && cfg_expect_phy)
                  warn_q <= 1'b1;
               done_q <= 1'b1;
               st     <= ST_DONE;
            end
            default: st <= ST_DONE;
         endcase
      end
   end

   // ---------------- address table
   logic tbl_wr, tbl_fallback;
   assign tbl_wr       = (st == ST_CHOOSE);
   assign tbl_fallback = (st == ST_FINISH) && (cnt_q == '0) && cfg_expect_phy;

   generate
      for (g = 0; g < MAX_PHYS; g++) begin : g_tbl
         logic [4:0] ent_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               ent_q <= '0;
            else if (tbl_wr && cnt_q == CNT_W'(g))
               ent_q <= idx_q[4:0];
            else if (tbl_fallback && g == 0)
               ent_q <= 5'd1;
         end
         assign phy_addr_tbl[5*g +: 5] = ent_q;
      end
   endgenerate

   // ---------------- master port
   always_comb begin
      mdio_req   = 1'b0;
      mdio_wr    = 1'b0;
      mdio_reg   = REG_CTRL;
      mdio_wdata = new_ctrl_q;
      case (st)
         ST_RD_STAT:  begin mdio_req = 1'b1; mdio_reg = REG_STAT; end
         ST_RD_CTRL:  begin mdio_req = 1'b1; mdio_reg = REG_CTRL; end
         ST_RD_ADV:   begin mdio_req = 1'b1; mdio_reg = REG_ADV;  end
         ST_WR_ADV:   begin mdio_req = 1'b1; mdio_wr = 1'b1; mdio_reg = REG_ADV;
                            mdio_wdata = chosen_q; end
         ST_WR_CTRL1,
         ST_WR_CTRL2: begin mdio_req = 1'b1; mdio_wr = 1'b1; end
         default: ;
      endcase
   end

   assign mdio_phy    = idx_q[4:0];
   assign phy_count   = cnt_q;
   assign no_phy_warn = warn_q;
   assign done        = done_q;

   // ---------------- assertions
   // R11: request fields held until acknowledged
   p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (mdio_req && !mdio_ack) |=> (mdio_req && $stable(mdio_phy) && $stable(mdio_reg)
                                   && $stable(mdio_wr) && $stable(mdio_wdata)));

   // R9: done is a single-cycle pulse and nothing is requested afterwards
   p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (!done && !mdio_req));

   // R1: table never overfills
   p_count_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
      phy_count <= CNT_W'(MAX_PHYS));

   // R10: warning only when nothing was recorded
   p_warn_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
      no_phy_warn |-> (phy_count == '0));

   // R8: second control write only after the settle window elapsed
   p_settle_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(st) == ST_SETTLE && st == ST_WR_CTRL2) |-> $past(tmr_zero));

   // R5: writes target only control or advertisement
   p_wr_target_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (mdio_req && mdio_wr) |-> (mdio_reg == REG_CTRL || mdio_reg == REG_ADV));

endmodule

// File: tb/test_phy_scan_seq.sv
module test_phy_scan_seq;

   localparam int CLK_PERIOD = 10;
   localparam int MAXP       = 4;
   localparam int SETTLE     = 12;
   localparam int LAT        = 2;
   localparam int CW         = $clog2(MAXP + 1);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_forced = 0, cfg_full_duplex = 0, cfg_speed100 = 0, cfg_expect_phy = 0;
   logic [15:0] cfg_adv_preset = '0;
   logic [16*MAXP-1:0] cfg_slot_adv = '0;
   logic mdio_req, mdio_wr;
   logic [4:0] mdio_phy, mdio_reg;
   logic [15:0] mdio_wdata;
   logic mdio_ack = 1'b0;
   logic [15:0] mdio_rdata = '0;
   logic [5*MAXP-1:0] phy_addr_tbl;
   logic [CW-1:0] phy_count;
   logic no_phy_warn, done;

   always #(CLK_PERIOD/2) clk = ~clk;

   phy_scan_seq #(.MAX_PHYS(MAXP), .SETTLE_CYC(SETTLE)) i_phy_scan_seq (
      .clk, .rst_n, .cfg_forced, .cfg_full_duplex, .cfg_speed100, .cfg_expect_phy,
      .cfg_adv_preset, .cfg_slot_adv, .mdio_req, .mdio_wr, .mdio_phy, .mdio_reg,
      .mdio_wdata, .mdio_ack, .mdio_rdata, .phy_addr_tbl, .phy_count, .no_phy_warn, .done
   );

   int n_checks = 0;
   int n_fail   = 0;
   int cyc      = 0;
   always @(posedge clk) cyc <= cyc + 1;

   // PHY model
   logic        present [32];
   logic [15:0] m_stat  [32];
   logic [15:0] m_ctrl  [32];
   logic [15:0] m_adv   [32];

   // transaction logs
   int         n_wr = 0, n_st = 0;
   logic [4:0] w_phy [64];
   logic [4:0] w_reg [64];
   logic [15:0] w_dat [64];
   int         w_cyc [64];
   logic [4:0] st_phy [64];

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   // bus responder
   initial begin
      int lat = 0;
      forever begin
         @(negedge clk);
         if (mdio_ack) begin
            mdio_ack = 1'b0;
         end else if (mdio_req) begin
            lat++;
            if (lat == LAT) begin
               lat = 0;
               mdio_ack = 1'b1;
               if (mdio_wr) begin
                  if (n_wr < 64) begin
                     w_phy[n_wr] = mdio_phy; w_reg[n_wr] = mdio_reg;
                     w_dat[n_wr] = mdio_wdata; w_cyc[n_wr] = cyc;
                  end
                  n_wr++;
                  if (present[mdio_phy]) begin
                     if (mdio_reg == 5'd0) m_ctrl[mdio_phy] = mdio_wdata;
                     if (mdio_reg == 5'd4) m_adv[mdio_phy]  = mdio_wdata;
                  end
               end else begin
                  if (mdio_reg == 5'd1) begin
                     if (n_st < 64) st_phy[n_st] = mdio_phy;
                     n_st++;
                  end
                  if (!present[mdio_phy])      mdio_rdata = 16'hFFFF;
                  else if (mdio_reg == 5'd1)   mdio_rdata = m_stat[mdio_phy];
                  else if (mdio_reg == 5'd0)   mdio_rdata = m_ctrl[mdio_phy];
                  else if (mdio_reg == 5'd4)   mdio_rdata = m_adv[mdio_phy];
                  else                         mdio_rdata = 16'h0000;
               end
            end
         end else begin
            lat = 0;
         end
      end
   end

   task automatic clear_phys();
      for (int a = 0; a < 32; a++) begin
         present[a] = 1'b0; m_stat[a] = '0; m_ctrl[a] = '0; m_adv[a] = '0;
      end
   endtask

   task automatic add_phy(input int a, input logic [15:0] s, input logic [15:0] c,
                          input logic [15:0] v);
      present[a] = 1'b1; m_stat[a] = s; m_ctrl[a] = c; m_adv[a] = v;
   endtask

   function automatic logic [4:0] tbl(input int k);
      return phy_addr_tbl[5*k +: 5];
   endfunction

   // reset, run to completion, check the done pulse and quiet bus (R9)
   task automatic run_scan();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      n_wr = 0; n_st = 0;
      rst_n = 1'b1;
      do @(negedge clk); while (!done);
   endtask

   task automatic check_tail();
      bit quiet = 1'b1;
      @(negedge clk);
      chk(!done, "R9 done pulse width", done, 0);
      for (int k = 0; k < 10; k++) begin
         if (mdio_req) quiet = 1'b0;
         @(negedge clk);
      end
      chk(quiet, "R9 no request after done", quiet, 1);
   endtask

   task automatic t_reset_state();
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      chk(!done && !no_phy_warn && !mdio_req, "R12 reset outputs",
          {done, no_phy_warn, mdio_req}, 0);
      chk(phy_count == 0 && phy_addr_tbl == 0, "R12 reset table/count",
          phy_addr_tbl, 0);
   endtask

   // autoneg enable, derived and global advertisement, order, rejections
   task automatic t_autoneg_mix();
      bit order_ok = 1'b1;
      clear_phys();
      add_phy(3, 16'h7809, 16'h0000, 16'h0000);
      add_phy(0, 16'h8001, 16'h3100, 16'h0061);
      add_phy(5, 16'h0001, 16'h0000, 16'h01E1);
      add_phy(7, 16'h8101, 16'h0000, 16'h01E1);
      cfg_forced = 0; cfg_full_duplex = 0; cfg_speed100 = 0; cfg_expect_phy = 1;
      cfg_adv_preset = 16'h0000; cfg_slot_adv = '0;
      run_scan();
      chk(phy_count == 2, "R9 count two phys", phy_count, 2);
      chk(tbl(0) == 3 && tbl(1) == 0, "R1 table order 3 then 0",
          {tbl(1), tbl(0)}, {5'd0, 5'd3});
      chk(!no_phy_warn, "R10 no warning when found", no_phy_warn, 0);
      chk(n_st == 32, "R1 status reads cover all addresses", n_st, 32);
      for (int k = 0; k < 31; k++) if (st_phy[k] != 5'(k + 1)) order_ok = 1'b0;
      chk(order_ok && st_phy[31] == 0, "R1 scan order 1..31 then 0", st_phy[31], 0);
      chk(n_wr == 4, "R2 R5 R8 write count", n_wr, 4);
      chk(w_phy[0] == 3 && w_reg[0] == 0 && w_dat[0] == 16'h1200,
          "R6 ane set with restart", w_dat[0], 16'h1200);
      chk(w_phy[1] == 3 && w_reg[1] == 0 && w_dat[1] == 16'h1200,
          "R8 second identical control write", w_dat[1], 16'h1200);
      chk(w_cyc[1] - w_cyc[0] >= SETTLE, "R8 settle gap", w_cyc[1] - w_cyc[0], SETTLE);
      chk(m_adv[3] == 16'h0000, "R3 R5 derived adv equal, reg4 untouched", m_adv[3], 0);
      chk(w_phy[2] == 0 && w_reg[2] == 4 && w_dat[2] == 16'h01E1,
          "R4 derived value becomes global", w_dat[2], 16'h01E1);
      chk(w_phy[3] == 0 && w_reg[3] == 0 && w_dat[3] == 16'h1000,
          "R7 scrub to single write", w_dat[3], 16'h1000);
      check_tail();
   endtask

   // forced media with preset advertisement
   task automatic t_forced_media();
      clear_phys();
      add_phy(2, 16'h7809, 16'h1000, 16'h01E1);
      add_phy(9, 16'h8001, 16'h2100, 16'h05E1);
      cfg_forced = 1; cfg_full_duplex = 1; cfg_speed100 = 1; cfg_expect_phy = 0;
      cfg_adv_preset = 16'h05E1; cfg_slot_adv = '0;
      run_scan();
      chk(phy_count == 2 && tbl(0) == 2 && tbl(1) == 9, "R9 forced table",
          {tbl(1), tbl(0)}, {5'd9, 5'd2});
      chk(n_wr == 3, "R8 forced write count", n_wr, 3);
      chk(w_phy[0] == 2 && w_reg[0] == 4 && w_dat[0] == 16'h05E1,
          "R4 preset wins", w_dat[0], 16'h05E1);
      chk(w_reg[1] == 0 && w_dat[1] == 16'h2100 && w_reg[2] == 0 && w_dat[2] == 16'h2100,
          "R6 R7 forced control fdx+100", w_dat[1], 16'h2100);
      chk(w_cyc[2] - w_cyc[1] >= SETTLE, "R8 forced settle gap",
          w_cyc[2] - w_cyc[1], SETTLE);
      chk(m_ctrl[9] == 16'h2100 && m_adv[9] == 16'h05E1,
          "R8 unchanged phy not written", m_ctrl[9], 16'h2100);
      check_tail();
   endtask

   // stored slot advertisement and early stop on full table
   task automatic t_slot_and_full();
      clear_phys();
      for (int a = 1; a <= 6; a++) add_phy(a, 16'h8001, 16'h1000, 16'h01E1);
      cfg_forced = 0; cfg_full_duplex = 0; cfg_speed100 = 0; cfg_expect_phy = 1;
      cfg_adv_preset = 16'h0000;
      cfg_slot_adv = '0;
      cfg_slot_adv[15:0]  = 16'h0021;
      cfg_slot_adv[47:32] = 16'h0041;
      run_scan();
      chk(phy_count == MAXP, "R1 table full", phy_count, MAXP);
      chk(tbl(0) == 1 && tbl(1) == 2 && tbl(2) == 3 && tbl(3) == 4,
          "R9 table 1..4", phy_addr_tbl, 0);
      chk(n_st == 4 && st_phy[3] == 4, "R1 stop when full, addr 5 unread", n_st, 4);
      chk(n_wr == 1 && w_phy[0] == 1 && w_reg[0] == 4 && w_dat[0] == 16'h0021,
          "R4 slot value used, global then wins", n_wr, 1);
      chk(m_adv[3] == 16'h01E1, "R4 global beats slot 2", m_adv[3], 16'h01E1);
      check_tail();
   endtask

   task automatic t_none_expected();
      clear_phys();
      add_phy(12, 16'h0001, 16'h0000, 16'h0000);
      cfg_forced = 0; cfg_expect_phy = 1; cfg_adv_preset = '0; cfg_slot_adv = '0;
      run_scan();
      chk(phy_count == 0 && no_phy_warn, "R10 warning raised", no_phy_warn, 1);
      chk(tbl(0) == 1, "R10 fallback address", tbl(0), 1);
      chk(n_wr == 0, "R2 rejected phy untouched", n_wr, 0);
      check_tail();
   endtask

   task automatic t_none_unexpected();
      clear_phys();
      cfg_expect_phy = 0;
      run_scan();
      chk(!no_phy_warn && phy_addr_tbl == 0 && phy_count == 0,
          "R10 no warning when not expected", no_phy_warn, 0);
      check_tail();
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      n_checks++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end

   initial begin
      clear_phys();
      t_reset_state();
      t_autoneg_mix();
      t_forced_media();
      t_slot_and_full();
      t_none_expected();
      t_none_unexpected();
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end

endmodule